// File: doc/BRIEF.md
# On-Off Cycle-Skipping Gate Controller

This block drives the gate of an off-line power switch under on/off regulation. Pulse width is not modulated. At each cycle-start pulse from the oscillator it samples a synchronized feedback level once. If the level is high, the switch conducts for that cycle. If it is low, the whole cycle is skipped. Once conduction has begun, it ends at the first of these events: the duty-limit window closes, the current-limit comparator trips after the blanking interval, or a protection condition appears.

Two hysteretic lockouts gate every start. The supply lockout is set by a below-threshold flag and cleared by a recovered flag. The thermal lockout is set by an over-temperature flag and cleared by a cooled flag. An external disable, driven by a fault timer elsewhere, also blocks switching. All comparator thresholds arrive as digital flags. The feedback and current-limit flags are asynchronous and pass through a two-flop synchronizer. The lockout flags, the disable and the oscillator signals are assumed to be synchronous to the system clock.

Top module: `onoff_gate_ctrl`

## Requirements
- R1: On a clock edge where `cyc_start` is high, the synchronized feedback level is sampled. If it is high (and no lockout or disable is active), `gate` goes high from the next cycle and `cyc_en` reads 1 for the whole cycle. If it is low, `gate` stays low for the whole cycle and `cyc_en` reads 0.
- R2: A change of `fb_in` after the sampling edge has no effect on `gate` for the rest of that cycle.
- R3: When `duty_win` is seen low at a clock edge while the switch conducts, `gate` is low from that edge on.
- R4: `ilim_in` passes through two synchronizer flops. Outside the blanking interval, `gate` falls on the third rising edge after `ilim_in` rises and stays low until the next cycle start.
- R5: For `BLANK_TICKS` edges after the turn-on edge the current-limit flag is ignored. The earliest current-limit turn-off is at edge `BLANK_TICKS`+1 after turn-on.
- R6: The supply lockout is set by a high `uv_set` and cleared by a high `uv_clr`. Set wins if both are high. The lockout is set out of reset (default `UV_LOCK_AT_RESET`=1). While it is set, no cycle turns on. When it sets mid-cycle, `gate` is low from the next clock. When it clears mid-cycle, conduction resumes only at the next cycle start.
- R7: The thermal lockout behaves like the supply lockout, using `ot_set`/`ot_clr`, and is clear out of reset. It stays set after `ot_set` falls, until `ot_clr` is seen.
- R8: `ext_dis` forces `gate` low combinationally in the same cycle. Conduction does not come back after `ext_dis` is released within that cycle. A start while `ext_dis` is high is skipped.
- R9: `fb_in` must be stable for two clock edges before the start edge to be seen. A level that changes only one cycle before the start is not yet visible.
- R10: After reset, `gate` and `cyc_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a switching cycle |
| duty_win | input | 1 | High while the duty-limit window allows conduction |
| fb_in | input | 1 | Asynchronous feedback enable level |
| ilim_in | input | 1 | Asynchronous current-limit comparator flag |
| uv_set | input | 1 | Supply below lower threshold |
| uv_clr | input | 1 | Supply back above upper threshold |
| ot_set | input | 1 | Die temperature above trip point |
| ot_clr | input | 1 | Die temperature back below trip point minus hysteresis |
| ext_dis | input | 1 | External disable from the fault timer |
| gate | output | 1 | Power switch gate drive |
| cyc_en | output | 1 | Current cycle was enabled at its start |

## Verification
The bench builds the block with `BLANK_TICKS`=4 and the supply lockout set at reset, inside a 16-clock cycle whose duty window lasts 12 clocks. This short blanking lets current-limit trips land inside, exactly at, and past the blanking boundary, as well as after the duty window ends, all within one cycle. The reset lockout setting means the first cycles exercise the rule that a lockout clearing mid-cycle only takes effect at the next start. Feedback lead times of one and two clocks probe the synchronizer depth at the sampling edge.

// File: rtl/onoff_pkg.sv
// Shared constants and types for the on-off gate controller.
// Assumes: all consumers import this package; nothing here holds state.
package onoff_pkg;
    // Depth of the synchronizer on asynchronous comparator inputs.
    localparam int SYNC_STAGES = 2;

    // Hysteretic lockout request: one flag trips it, another releases it.
    typedef struct packed {
        logic set;
        logic clr;
    } lock_req_t;
endpackage

// File: rtl/onoff_sync.sv
// Multi-bit flop-chain synchronizer for independent asynchronous levels.
// Assumes: each bit is a slow level; no bus coherency between bits is needed.
module onoff_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the levels through the chain, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/onoff_hyst_lock.sv
// Hysteretic lockout latch: trips on a set flag, releases on a clear flag.
// Assumes: flags are synchronous to clk; set has priority over clear.
module onoff_hyst_lock
    import onoff_pkg::*;
#(
    parameter bit RESET_LOCKED = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  lock_req_t req,
    output logic      locked
);
    // Hold the lock state between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= RESET_LOCKED;
        else if (req.set)  locked <= 1'b1;
        else if (req.clr)  locked <= 1'b0;
    end
endmodule

// File: rtl/onoff_blank_timer.sv
// Leading-edge blanking timer: counts down from TICKS after each load.
// Assumes: load is a single-cycle pulse at switch turn-on.
module onoff_blank_timer #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(TICKS + 2);
    localparam logic [CW-1:0] LOAD_VAL = CW'(TICKS);

    logic [CW-1:0] cnt;

    // Reload on turn-on, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/onoff_gate_ctrl.sv
// On-off cycle-skipping gate controller.
// Samples synchronized feedback once per cycle start and turns the gate on
// for the cycle or skips it. It turns the gate off on duty-window end, on a
// blanked current-limit trip, or on lockout/disable.
// Assumes: cyc_start, duty_win, lockout flags and ext_dis are synchronous;
// fb_in and ilim_in are asynchronous levels.
module onoff_gate_ctrl
    import onoff_pkg::*;
#(
    parameter int BLANK_TICKS      = 4,
    parameter bit UV_LOCK_AT_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic duty_win,
    input  logic fb_in,
    input  logic ilim_in,
    input  logic uv_set,
    input  logic uv_clr,
    input  logic ot_set,
    input  logic ot_clr,
    input  logic ext_dis,
    output logic gate,
    output logic cyc_en
);
    localparam int N_LOCK = 2;
    localparam int L_UV   = 0;
    localparam int L_OT   = 1;

    logic              fb_s;
    logic              ilim_s;
    lock_req_t         lreq [N_LOCK];
    logic [N_LOCK-1:0] locked;
    logic              kill;
    logic              start_ok;
    logic              blank_done;
    logic              gate_q;

    // Bring the two asynchronous comparator levels into the clock domain.
    onoff_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fb_in, ilim_in}),
        .q     ({fb_s, ilim_s})
    );

    // Route each protection's flags to its own lockout latch.
    always_comb begin
        lreq[L_UV] = '{set: uv_set, clr: uv_clr};
        lreq[L_OT] = '{set: ot_set, clr: ot_clr};
    end

    for (genvar k = 0; k < N_LOCK; k++) begin : g_lock
        onoff_hyst_lock #(
            .RESET_LOCKED ((k == L_UV) ? UV_LOCK_AT_RESET : 1'b0)
        ) u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (lreq[k]),
            .locked (locked[k])
        );
    end

    // Any protection or external disable blocks conduction.
    assign kill     = ext_dis | (|locked);
    assign start_ok = fb_s & duty_win & ~kill;

    onoff_blank_timer #(
        .TICKS (BLANK_TICKS)
    ) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cyc_start & start_ok),
        .done  (blank_done)
    );

    // Decide conduction at cycle start; end it on the first turn-off event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            cyc_en <= 1'b0;
        end else if (cyc_start) begin
            gate_q <= start_ok;
            cyc_en <= start_ok;
        end else if (gate_q && (!duty_win || kill || (ilim_s && blank_done))) begin
            gate_q <= 1'b0;
        end
    end

    // Protections cut the drive at once without waiting for a clock edge.
    assign gate = gate_q & ~kill;
endmodule

// File: rtl/onoff_gate_ctrl_chk.sv
// Property checker for the on-off gate controller, bound into the top.
// Assumes: connected through the bind below; observes only.
module onoff_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic duty_win,
    input logic uv_set,
    input logic ot_set,
    input logic ext_dis,
    input logic fb_s,
    input logic gate,
    input logic cyc_en
);
    // R1
    gate_rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(cyc_start));

    // R1
    skip_on_low_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !fb_s) |=> (!gate && !cyc_en));

    // R3
    duty_end_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!duty_win && !cyc_start) |=> !gate);

    // R6
    uv_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_set |=> !gate);

    // R7
    ot_trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_set |=> !gate);

    // R8
    ext_dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dis |=> !gate);
endmodule

bind onoff_gate_ctrl onoff_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .duty_win  (duty_win),
    .uv_set    (uv_set),
    .ot_set    (ot_set),
    .ext_dis   (ext_dis),
    .fb_s      (fb_s),
    .gate      (gate),
    .cyc_en    (cyc_en)
);

// File: tb/test_onoff_gate_ctrl.sv
// Self-checking bench: a vector table of single cycles, then directed tests.
module test_onoff_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK      = 4;
    localparam int DUTY       = 12;
    localparam int PER        = 16;

    typedef struct packed {
        logic       fb;
        logic       flip;
        logic [7:0] ilim_k;
        logic [7:0] exp_w;
        logic       exp_en;
    } vec_t;

    // Widths: ilim at tick k ends at max(k+2, BLANK+1), capped by DUTY.
    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b0, 8'd0,  8'd12, 1'b1},
        '{1'b0, 1'b0, 8'd0,  8'd0,  1'b0},
        '{1'b1, 1'b1, 8'd0,  8'd12, 1'b1},
        '{1'b0, 1'b1, 8'd0,  8'd0,  1'b0},
        '{1'b1, 1'b0, 8'd1,  8'd5,  1'b1},
        '{1'b1, 1'b0, 8'd3,  8'd5,  1'b1},
        '{1'b1, 1'b0, 8'd4,  8'd6,  1'b1},
        '{1'b1, 1'b0, 8'd8,  8'd10, 1'b1},
        '{1'b1, 1'b0, 8'd11, 8'd12, 1'b1},
        '{1'b0, 1'b0, 8'd2,  8'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, duty_win = 1'b0, fb_in = 1'b0, ilim_in = 1'b0;
    logic uv_set = 1'b0, uv_clr = 1'b0, ot_set = 1'b0, ot_clr = 1'b0;
    logic ext_dis = 1'b0;
    logic gate, cyc_en;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    onoff_gate_ctrl #(
        .BLANK_TICKS      (BLANK),
        .UV_LOCK_AT_RESET (1'b1)
    ) i_onoff_gate_ctrl (
        .clk (clk), .rst_n (rst_n), .cyc_start (cyc_start), .duty_win (duty_win),
        .fb_in (fb_in), .ilim_in (ilim_in), .uv_set (uv_set), .uv_clr (uv_clr),
        .ot_set (ot_set), .ot_clr (ot_clr), .ext_dis (ext_dis),
        .gate (gate), .cyc_en (cyc_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One switching cycle; pulse ticks of 0 mean "no pulse", ext_to 0 means no disable.
    task automatic do_cycle(input string tag, input logic fb, input logic flip,
                            input int lead, input int ilim_k,
                            input int uvs, input int uvc, input int ots, input int otc,
                            input int ext_from, input int ext_to,
                            input int exp_w, input logic exp_en);
        int w = 0;
        logic en_seen = 1'b0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            fb_in = (j >= 4 - lead) ? fb : 1'b0;
            cyc_start = 1'b0; duty_win = 1'b0; ilim_in = 1'b0;
            uv_set = 1'b0; uv_clr = 1'b0; ot_set = 1'b0; ot_clr = 1'b0; ext_dis = 1'b0;
        end
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i >= 1 && gate) w++;
            if (i == 1) en_seen = cyc_en;
            cyc_start = (i == 0);
            duty_win  = (i < DUTY);
            ilim_in   = (ilim_k > 0 && i >= ilim_k && i < DUTY);
            fb_in     = (flip && i >= 2) ? ~fb : fb;
            uv_set    = (uvs > 0 && i == uvs);
            uv_clr    = (uvc > 0 && i == uvc);
            ot_set    = (ots > 0 && i == ots);
            ot_clr    = (otc > 0 && i == otc);
            ext_dis   = (ext_to > 0 && i >= ext_from && i < ext_to);
            if (ext_to > 0 && ext_from > 0 && i == ext_from) begin
                #1;
                chk(gate == 1'b0, "R8 immediate cut", int'(gate), 0);
            end
        end
        chk(w == exp_w, {tag, " width"}, w, exp_w);
        chk(en_seen == exp_en, {tag, " cyc_en"}, int'(en_seen), int'(exp_en));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: outputs idle after reset
        chk(gate == 1'b0, "R10 gate", int'(gate), 0);
        chk(cyc_en == 1'b0, "R10 cyc_en", int'(cyc_en), 0);

        // R6: supply lockout set from reset; clearing mid-cycle waits for next start
        do_cycle("R6 locked at reset", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        do_cycle("R6 clear mid-cycle", 1'b1, 1'b0, 3, 0, 0, 5, 0, 0, 0, 0, 0, 1'b0);

        // Table walk: R1 feedback, R2 late change, R4/R5 current limit and blanking, R3 duty end
        for (int v = 0; v < 10; v++) begin
            string tag;
            if (VEC[v].flip)            tag = "R2 late fb change";
            else if (VEC[v].ilim_k > 0) tag = "R4 R5 current limit";
            else                        tag = "R1 R3 fb sample";
            do_cycle(tag, VEC[v].fb, VEC[v].flip, 3, int'(VEC[v].ilim_k),
                     0, 0, 0, 0, 0, 0, int'(VEC[v].exp_w), VEC[v].exp_en);
        end

        // R6: trip mid-cycle, release mid-cycle, resume next cycle
        do_cycle("R6 trip mid", 1'b1, 1'b0, 3, 0, 3, 6, 0, 0, 0, 0, 3, 1'b1);
        do_cycle("R6 resume", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 0, 12, 1'b1);
        // R6: lock holds with no clear, set wins over clear
        do_cycle("R6 trip hold", 1'b1, 1'b0, 3, 0, 3, 0, 0, 0, 0, 0, 3, 1'b1);
        do_cycle("R6 held", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        do_cycle("R6 released", 1'b1, 1'b0, 3, 0, 0, 2, 0, 0, 0, 0, 0, 1'b0);
        do_cycle("R6 set wins", 1'b1, 1'b0, 3, 0, 4, 4, 0, 0, 0, 0, 4, 1'b1);
        do_cycle("R6 set won", 1'b1, 1'b0, 3, 0, 0, 2, 0, 0, 0, 0, 0, 1'b0);

        // R7: thermal lockout trips, holds after flag drops, then releases
        do_cycle("R7 trip mid", 1'b1, 1'b0, 3, 0, 0, 0, 5, 0, 0, 0, 5, 1'b1);
        do_cycle("R7 held", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        do_cycle("R7 release", 1'b1, 1'b0, 3, 0, 0, 0, 0, 2, 0, 0, 0, 1'b0);
        do_cycle("R7 resume", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 0, 12, 1'b1);

        // R8: external disable mid-cycle, and held across a start
        do_cycle("R8 mid-cycle", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 3, 6, 3, 1'b1);
        do_cycle("R8 over start", 1'b1, 1'b0, 3, 0, 0, 0, 0, 0, 0, 4, 0, 1'b0);

        // R9: feedback needs two edges of lead before the start edge
        do_cycle("R9 lead 1", 1'b1, 1'b0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        do_cycle("R9 lead 2", 1'b1, 1'b0, 2, 0, 0, 0, 0, 0, 0, 0, 12, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule